// File: doc/BRIEF.md
# Pixel Link Stress Pattern Generator

This block sources a fixed-width pixel word for a parallel-to-serial display link so that the link's power draw and its worst-case switching behaviour can be measured without a real video source. On every pixel clock it emits one word. The word follows one of four selectable patterns:

- a checkerboard that toggles every bit on every cycle;
- a grayscale stripe pattern in which each low colour bit runs at its own fixed fraction of the pixel rate;
- a seven-bit pseudo-random sequence copied onto every serial lane;
- a blank all-zero word.

The word is laid out for 18-bit colour. Red, green and blue occupy consecutive six-bit fields starting at bit 0. The horizontal sync, vertical sync and data-enable controls sit directly above the blue field. Whenever the mode select changes, the pattern restarts from its first word. This gives a measurement a known starting point.

Top module: `pix_pattern_gen`

## Requirements
- R1: While `rst` is high, `pix_word` reads all zeros. After the first rising edge with `rst` low, `pix_word` holds pattern word 0 of the selected mode, and word n follows n edges later.
- R2: Mode code 0 is the checkerboard. Word n is 28'h5555555 (even bits high, odd bits low) for even n and 28'hAAAAAAA for odd n.
- R3: Mode code 1 is grayscale. In each colour field (red bits 5:0, green bits 11:6, blue bits 17:12), colour bit k for k = 0..3 of word n equals bit (3-k) of n mod 16. Bit 0 therefore has a 16-cycle period, bit 1 an 8-cycle period, bit 2 a 4-cycle period and bit 3 a 2-cycle period.
- R4: In grayscale mode, colour bits 4 and 5 of every field and word bits 27:21 stay low.
- R5: In grayscale mode, HS (bit 18), VS (bit 19) and DE (bit 20) stay high.
- R6: Mode code 2 is the pseudo-random pattern. The four 7-bit lanes (bits 6:0, 13:7, 20:14, 27:21) all carry state s_n. s_0 = 7'h7F and s_{n+1} = {s_n[5:0], s_n[6] ^ s_n[5]}, which is the x^7+x^6+1 recurrence.
- R7: The pseudo-random lane value is never zero and repeats with a period of exactly 127 words.
- R8: Mode code 3 gives an all-zero word.
- R9: When the edge samples a `mode_sel` value that differs from the one sampled at the previous edge, the word from that edge still comes from the old pattern. The next edge delivers word 0 of the new mode. This holds for a change that lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pattern select: 0 checkerboard, 1 grayscale, 2 pseudo-random, 3 blank |
| pix_word | output | 28 | Registered pixel word toward the serializer |

## Verification
The bench builds the block with its default parameters: six-bit colour fields, four stripe bits, four lanes of seven bits, and an all-ones seed. With these values the whole 16-cycle stripe period and the full 127-word pseudo-random period fit into a few hundred cycles, so each repeats at least once inside one run. The expected words are derived in the bench from the stripe formula and the recurrence. The run also covers a reset in the middle of a pattern and a mode change that lasts one cycle.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  typedef enum logic [1:0] {
    PG_CHECKER = 2'd0,
    PG_GRAY    = 2'd1,
    PG_PRBS    = 2'd2,
    PG_BLANK   = 2'd3
  } pg_mode_e;

endpackage

// File: rtl/pgen_mode_track.sv
module pgen_mode_track
  import pgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  output pg_mode_e   mode_q,
  output logic       restart
);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= pg_mode_e'(mode_sel);
    else     mode_q <= pg_mode_e'(mode_sel);
  end

  assign restart = (mode_sel != mode_q) && !rst;

  // R9
  mode_follow_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == pg_mode_e'($past(mode_sel)));

endmodule

// File: rtl/pgen_stripe_cnt.sv
module pgen_stripe_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  // R9
  stripe_restart_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> cnt == '0);

  // R3
  stripe_step_chk: assert property (@(posedge clk) disable iff (rst)
    !restart |=> cnt == $past(cnt) + 1'b1);

endmodule

// File: rtl/pgen_lfsr.sv
module pgen_lfsr #(
  parameter int         W     = 7,
  parameter int         TAP_A = 6,
  parameter int         TAP_B = 5,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  output logic [W-1:0] state
);

  logic fb;
  assign fb = state[TAP_A] ^ state[TAP_B];

  always_ff @(posedge clk) begin
    if (rst || restart) state <= SEED;
    else                state <= {state[W-2:0], fb};
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    state != '0);

  // R6
  lfsr_seed_chk: assert property (@(posedge clk) disable iff (rst)
    restart |=> state == SEED);

endmodule

// File: rtl/pgen_word_mux.sv
module pgen_word_mux
  import pgen_pkg::*;
#(
  parameter int COLOR_W     = 6,
  parameter int STRIPE_BITS = 4,
  parameter int LANES       = 4,
  parameter int LANE_W      = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  pg_mode_e                  mode_q,
  input  logic [STRIPE_BITS-1:0]    cnt,
  input  logic [LANE_W-1:0]         prbs,
  output logic [LANES*LANE_W-1:0]   pix_word
);

  localparam int WORD_W = LANES * LANE_W;
  localparam int HS_POS = 3 * COLOR_W;
  localparam int VS_POS = HS_POS + 1;
  localparam int DE_POS = HS_POS + 2;

  logic [WORD_W-1:0] chk_w, gray_w, prbs_w, next_w;

  genvar g;
  generate
    for (g = 0; g < WORD_W; g++) begin : g_chk
      if (g % 2 == 0) begin : g_even
        assign chk_w[g] = ~cnt[0];
      end else begin : g_odd
        assign chk_w[g] = cnt[0];
      end
    end
    for (g = 0; g < LANES; g++) begin : g_lane
      assign prbs_w[g*LANE_W +: LANE_W] = prbs;
    end
  endgenerate

  always_comb begin
    gray_w = '0;
    for (int c = 0; c < 3; c++) begin
      for (int k = 0; k < STRIPE_BITS; k++) begin
        gray_w[c*COLOR_W + k] = cnt[STRIPE_BITS-1-k];
      end
    end
    gray_w[HS_POS] = 1'b1;
    gray_w[VS_POS] = 1'b1;
    gray_w[DE_POS] = 1'b1;
  end

  always_comb begin
    case (mode_q)
      PG_CHECKER: next_w = chk_w;
      PG_GRAY:    next_w = gray_w;
      PG_PRBS:    next_w = prbs_w;
      default:    next_w = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pix_word <= '0;
    else     pix_word <= next_w;
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> pix_word == '0);

  // R2
  checker_half_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == PG_CHECKER |=> $countones(pix_word) == WORD_W/2);

  // R5
  gray_ctrl_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == PG_GRAY |=> pix_word[DE_POS:HS_POS] == 3'b111);

  // R8
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == PG_BLANK |=> pix_word == '0);

  // R7
  prbs_lane_chk: assert property (@(posedge clk) disable iff (rst)
    mode_q == PG_PRBS |=> pix_word[LANE_W-1:0] != '0);

endmodule

// File: rtl/pix_pattern_gen.sv
module pix_pattern_gen
  import pgen_pkg::*;
#(
  parameter int          COLOR_W     = 6,
  parameter int          STRIPE_BITS = 4,
  parameter int          LANES       = 4,
  parameter int          LANE_W      = 7,
  parameter logic [6:0]  PRBS_SEED   = 7'h7F
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_sel,
  output logic [LANES*LANE_W-1:0] pix_word
);

  localparam int TAP_A = LANE_W - 1;
  localparam int TAP_B = LANE_W - 2;

  pg_mode_e               mode_q;
  logic                   restart;
  logic [STRIPE_BITS-1:0] cnt;
  logic [LANE_W-1:0]      prbs;

  pgen_mode_track u_track (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .mode_q   (mode_q),
    .restart  (restart)
  );

  pgen_stripe_cnt #(.CNT_W(STRIPE_BITS)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .cnt     (cnt)
  );

  pgen_lfsr #(
    .W     (LANE_W),
    .TAP_A (TAP_A),
    .TAP_B (TAP_B),
    .SEED  (LANE_W'(PRBS_SEED))
  ) u_lfsr (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .state   (prbs)
  );

  pgen_word_mux #(
    .COLOR_W     (COLOR_W),
    .STRIPE_BITS (STRIPE_BITS),
    .LANES       (LANES),
    .LANE_W      (LANE_W)
  ) u_mux (
    .clk      (clk),
    .rst      (rst),
    .mode_q   (mode_q),
    .cnt      (cnt),
    .prbs     (prbs),
    .pix_word (pix_word)
  );

endmodule

// File: tb/pix_pattern_gen_tb.sv
module pix_pattern_gen_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_sel = 2'd3;
  logic [27:0] pix_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pix_pattern_gen u_dut (
    .clk      (clk),
    .rst      (rst),
    .mode_sel (mode_sel),
    .pix_word (pix_word)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [8:0] len;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{2'd1, 9'd40},
    '{2'd0, 9'd6},
    '{2'd2, 9'd140},
    '{2'd3, 9'd4},
    '{2'd1, 9'd20},
    '{2'd2, 9'd10},
    '{2'd0, 9'd3}
  };

  function automatic logic [6:0] prbs_at(int n);
    logic [6:0] s = 7'h7F;
    for (int i = 0; i < n; i++) s = {s[5:0], s[6] ^ s[5]};
    return s;
  endfunction

  function automatic logic [27:0] exp_word(logic [1:0] m, int n);
    logic [27:0] w = '0;
    case (m)
      2'd0: w = (n % 2 == 0) ? 28'h5555555 : 28'hAAAAAAA;
      2'd1: begin
        for (int c = 0; c < 3; c++)
          for (int k = 0; k < 4; k++)
            w[c*6 + k] = ((n % 16) >> (3 - k)) & 1;
        w[20:18] = 3'b111;
      end
      2'd2: w = {4{prbs_at(n)}};
      default: w = '0;
    endcase
    return w;
  endfunction

  task automatic chk(string req, logic [27:0] act, logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_mode(logic [1:0] m, int n);
    logic [27:0] e = exp_word(m, n);
    case (m)
      2'd0: chk("R2", pix_word, e);
      2'd1: begin
        chk("R3", pix_word & 28'h003CF3CF, e & 28'h003CF3CF);
        chk("R4", pix_word & 28'hFE30C30, 28'h0);
        chk("R5", pix_word & 28'h01C0000, 28'h01C0000);
      end
      2'd2: begin
        chk("R6", pix_word, e);
        checks++;
        if (pix_word[6:0] == 7'd0) begin
          errors++;
          $display("FAIL R7: actual %h expected nonzero", pix_word[6:0]);
        end
      end
      default: chk("R8", pix_word, 28'h0);
    endcase
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [27:0] w0;
    repeat (3) step();
    chk("R1", pix_word, 28'h0);
    rst = 1'b0;
    step();
    chk("R1", pix_word, 28'h0);
    for (int v = 0; v < 7; v++) begin
      mode_sel = VEC[v].mode;
      step();
      for (int i = 0; i < int'(VEC[v].len); i++) begin
        step();
        chk_mode(VEC[v].mode, i);
      end
    end
    // R7: the pseudo-random period is 127 words
    mode_sel = 2'd2;
    step();
    step();
    w0 = pix_word;
    chk("R6", w0, {4{7'h7F}});
    for (int i = 1; i < 127; i++) begin
      step();
      checks++;
      if (pix_word[6:0] == w0[6:0]) begin
        errors++;
        $display("FAIL R7: actual repeat at %0d expected period 127", i);
      end
    end
    step();
    chk("R7", pix_word, w0);
    // R1: a reset in the middle of a pattern
    step();
    rst = 1'b1;
    step();
    chk("R1", pix_word, 28'h0);
    step();
    chk("R1", pix_word, 28'h0);
    rst = 1'b0;
    step();
    chk("R1", pix_word, exp_word(2'd2, 0));
    step();
    chk("R1", pix_word, exp_word(2'd2, 1));
    // R9: a single-cycle mode change
    for (int i = 0; i < 5; i++) step();
    mode_sel = 2'd0;
    step();
    chk("R9", pix_word, exp_word(2'd2, 7));
    mode_sel = 2'd2;
    step();
    chk("R9", pix_word, 28'h5555555);
    step();
    chk("R9", pix_word, exp_word(2'd2, 0));
    step();
    chk("R9", pix_word, exp_word(2'd2, 1));
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule